// File: doc/BRIEF.md
# Receive Start-of-Packet Timestamp Capture

This block stamps every received frame with the value of a free-running system timer. Each time the receive gearbox on the reference lane hands out a word, the current timer value is captured. Nothing in the frame is inspected for a timing protocol, and the function cannot be switched off. Logic that does not need the timestamps can leave the outputs unconnected.

Captured values enter a delay line that is as deep as the decoder latency, counted in valid gearbox words. This keeps each captured value aligned with the decoded version of its own word. When the decoder flags a word as a start of packet, the value that belongs to that word leaves the line as the frame's timestamp, together with the PCS lane index on which the start of packet was seen.

The gearbox has a periodic dead cycle, about one in every 33. In that cycle no value is captured and the line does not move, so the alignment is kept across it. The timer is sampled in the same clock domain as the reference lane, and the block runs on that single clock.

Top module: `rx_sop_tstamp`

## Requirements
- R1: After a synchronous active-high reset, `tsValid` is 0 and `tsOut`/`tsLane` are 0. No timestamp is emitted until `DEC_DEPTH` valid words (`wordValid` = 1) have been captured since reset. A start-of-packet flag on any of those first `DEC_DEPTH` valid words is dropped.
- R2: In every cycle with `wordValid` = 1, `sysTime` is captured. In a valid-word cycle where `sopFlag` = 1 and the line is full, `tsValid` is 1 in the next cycle. At that point `tsOut` equals the `sysTime` captured exactly `DEC_DEPTH` valid words before the flagged cycle.
- R3: A cycle with `wordValid` = 0 (gearbox dead cycle) captures nothing and does not shift the delay line. A `sopFlag` in such a cycle is ignored and produces no pulse.
- R4: `tsLane` carries the `sopLane` value (5 bits, 0 to `NUM_LANES`-1) of the flagged cycle. It is registered together with `tsOut`.
- R5: Start-of-packet flags on consecutive valid words give `tsValid` pulses in consecutive cycles, each with its own timestamp and lane.
- R6: `tsValid` is high for exactly one cycle per accepted flag. Between pulses, `tsOut` and `tsLane` hold their last values.
- R7: A reset asserted mid-run clears the delay line. Output stays suppressed again until `DEC_DEPTH` new valid words have been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference lane receive clock |
| rst | input | 1 | Synchronous active-high reset |
| sysTime | input | TS_W | Free-running system timer value |
| wordValid | input | 1 | Gearbox word valid; low on a dead cycle |
| sopFlag | input | 1 | Decoder start-of-packet mark for the word decoded in this cycle |
| sopLane | input | LANE_W | PCS lane index on which the start of packet was seen |
| tsValid | output | 1 | One-cycle pulse for each filtered timestamp |
| tsOut | output | TS_W | Timestamp of the start-of-packet word |
| tsLane | output | LANE_W | PCS lane of the start of packet |

## Verification
The bench builds the block with `DEC_DEPTH` = 5 and the default 80-bit timer. A line that short fills within a few words, so the fill boundary after reset and after a mid-run reset are both reached many times. The timer steps by 3 each cycle, so a misaligned tap shows as a wrong value rather than a near miss. Dead cycles fall every 33rd cycle with a start-of-packet flag forced on them, and bursts of flags on consecutive words cross dead cycles, which brings line stalls and back-to-back pulses into the same windows.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
  typedef struct packed {
    logic shift;
    logic emit;
  } rxts_ctrl_t;
endpackage

// File: rtl/rxts_ctrl.sv
module rxts_ctrl #(
  parameter int DEPTH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wordValid,
  input  logic                sopFlag,
  output rxts_pkg::rxts_ctrl_t strobes
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] fillCnt;
  logic primed;

  assign primed = (fillCnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (wordValid && !primed) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shift = wordValid;
    strobes.emit  = wordValid && sopFlag && primed;
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= FULL);

  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wordValid |=> $stable(fillCnt));
endmodule

// File: rtl/rxts_datapath.sv
module rxts_datapath #(
  parameter int TS_W   = 80,
  parameter int LANE_W = 5,
  parameter int DEPTH  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rxts_pkg::rxts_ctrl_t strobes,
  input  logic [TS_W-1:0]      sysTime,
  input  logic [LANE_W-1:0]    sopLane,
  output logic                 tsValid,
  output logic [TS_W-1:0]      tsOut,
  output logic [LANE_W-1:0]    tsLane
);
  logic [TS_W-1:0] line [DEPTH];
  logic [TS_W-1:0] oldest;

  assign oldest = line[DEPTH-1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) line[i] <= '0;
        else if (strobes.shift) line[i] <= sysTime;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) line[i] <= '0;
        else if (strobes.shift) line[i] <= line[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tsValid <= 1'b0;
      tsOut   <= '0;
      tsLane  <= '0;
    end else begin
      tsValid <= strobes.emit;
      if (strobes.emit) begin
        tsOut  <= oldest;
        tsLane <= sopLane;
      end
    end
  end

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.shift |=> $stable(oldest));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.emit |=> ($stable(tsOut) && $stable(tsLane)));
endmodule

// File: rtl/rx_sop_tstamp.sv
module rx_sop_tstamp #(
  parameter int TS_W      = 80,
  parameter int LANE_W    = 5,
  parameter int NUM_LANES = 20,
  parameter int DEC_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   sysTime,
  input  logic              wordValid,
  input  logic              sopFlag,
  input  logic [LANE_W-1:0] sopLane,
  output logic              tsValid,
  output logic [TS_W-1:0]   tsOut,
  output logic [LANE_W-1:0] tsLane
);
  rxts_pkg::rxts_ctrl_t strobes;

  rxts_ctrl #(.DEPTH(DEC_DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wordValid(wordValid),
    .sopFlag  (sopFlag),
    .strobes  (strobes)
  );

  rxts_datapath #(.TS_W(TS_W), .LANE_W(LANE_W), .DEPTH(DEC_DEPTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .sysTime(sysTime),
    .sopLane(sopLane),
    .tsValid(tsValid),
    .tsOut  (tsOut),
    .tsLane (tsLane)
  );

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tsValid |-> $past(wordValid && sopFlag));

  // R4
  lane_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wordValid && sopFlag) |-> (sopLane < LANE_W'(NUM_LANES)));

  // R4
  lane_out_range_chk: assert property (@(posedge clk) disable iff (rst)
    tsValid |-> (tsLane < LANE_W'(NUM_LANES)));
endmodule

// File: tb/rx_sop_tstamp_bench.sv
module rx_sop_tstamp_bench;
  localparam int TS_W = 80;
  localparam int LANE_W = 5;
  localparam int DEPTH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TS_W-1:0] sysTime = '0;
  logic wordValid = 1'b0;
  logic sopFlag = 1'b0;
  logic [LANE_W-1:0] sopLane = '0;
  logic tsValid;
  logic [TS_W-1:0] tsOut;
  logic [LANE_W-1:0] tsLane;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  rx_sop_tstamp #(.TS_W(TS_W), .LANE_W(LANE_W), .NUM_LANES(20), .DEC_DEPTH(DEPTH)) u_rx_sop_tstamp (
    .clk(clk), .rst(rst), .sysTime(sysTime), .wordValid(wordValid),
    .sopFlag(sopFlag), .sopLane(sopLane),
    .tsValid(tsValid), .tsOut(tsOut), .tsLane(tsLane)
  );

  // behavioural reference model
  logic [TS_W-1:0] q[$];
  logic expValid = 1'b0;
  logic [TS_W-1:0] expTs = '0;
  logic [LANE_W-1:0] expLane = '0;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      expValid = 1'b0;
      expTs = '0;
      expLane = '0;
    end else begin
      expValid = 1'b0;
      if (wordValid) begin
        if (q.size() == DEPTH && sopFlag) begin
          expValid = 1'b1;
          expTs = q[0];
          expLane = sopLane;
        end
        q.push_back(sysTime);
        if (q.size() > DEPTH) void'(q.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (tsValid !== expValid) begin
        mismatched++;
        $display("FAIL %s tsValid actual %0b expected %0b", tag, tsValid, expValid);
      end
      compared++;
      if (tsOut !== expTs) begin
        mismatched++;
        $display("FAIL %s tsOut actual %0h expected %0h", tag, tsOut, expTs);
      end
      compared++;
      if (tsLane !== expLane) begin
        mismatched++;
        $display("FAIL %s/R4 tsLane actual %0d expected %0d", tag, tsLane, expLane);
      end
    end
  end

  int cyc = 0;
  task automatic step(input bit v, input bit s, input int lane);
    @(negedge clk);
    cyc++;
    sysTime   = sysTime + 3;
    wordValid = v;
    sopFlag   = s;
    sopLane   = LANE_W'(lane);
  endtask

  function automatic bit dead(input int c);
    return (c % 33) == 32;
  endfunction

  initial begin
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1, 1, 3);
    rst = 1'b0;
    // R1: flags during fill are dropped
    for (int i = 0; i < DEPTH; i++) step(1, 1, i);
    // R2/R3: mixed traffic with dead cycles carrying a forced flag
    for (int i = 0; i < 300; i++) begin
      if (dead(cyc + 1)) begin
        tag = "R3";
        step(0, 1, 7);
      end else begin
        tag = "R2";
        step(1, ($urandom_range(0, 3) == 0), int'($urandom_range(0, 19)));
      end
    end
    // R5: bursts of consecutive flags across dead cycles
    for (int i = 0; i < 200; i++) begin
      tag = "R5";
      if (dead(cyc + 1)) step(0, 1, 19);
      else step(1, 1, (i % 20));
    end
    // R6: long idle, outputs hold
    tag = "R6";
    for (int i = 0; i < 40; i++) step(1, 0, 11);
    // R7: mid-run reset, then refill
    tag = "R7";
    @(negedge clk); rst = 1'b1;
    step(1, 1, 2);
    step(1, 1, 2);
    rst = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (dead(cyc + 1)) step(0, 1, 5);
      else step(1, (i % 3 != 1), (i % 20));
    end
    step(0, 0, 0);
    step(0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog %s expired actual running expected finished", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule